// File: doc/BRIEF.md
# Optical Film Code Fixel-to-Byte Unpacker

This block turns one square optical data code, delivered as binarized fixel rows, into its ordered stream of payload bytes. The code is a 76 by 76 grid of fixels, where a transparent fixel reads as logic 1. Rows arrive one word at a time, top row first. The block gathers each horizontal band of four rows. It then walks that band left to right in blocks two fixels wide and four fixels tall, and turns every block that carries data into one byte.

Blocks that overlap the four 8x8 corner markers or the 12x12 central logo are skipped. A full code therefore yields 672 bytes. Each byte carries a running index, and a one-cycle completion pulse follows the last byte. A code sequence counter flags every byte of the periodic special code. A start-of-code input re-arms the block, and surplus rows beyond the grid height raise a sticky error.

Top module: `fixel_code_unpacker`

## Requirements
- R1: After synchronous reset, out_valid, code_done, out_special and row_error are 0, and out_index and out_byte are 0.
- R2: Bit k of a byte (k = 0..7) is the fixel at row 4b + (k mod 4) and column 2c + (k div 4), where b is the band and c is the block column. Row 0 is the first row after start_of_code, and bit j of row_data is column j, counted from the left.
- R3: Bytes come out in raster order of blocks: across a band from left to right, then band by band downward. Blocks whose top-left fixel lies in an 8x8 corner marker (rows and columns 0-7 or 68-75) or in the logo (rows and columns 32-43) emit nothing. out_index counts 0 to 671 with no gaps.
- R4: code_done is high for exactly one cycle, in the cycle after the byte with out_index 671 is presented.
- R5: Codes are numbered from 0 after reset, and the number advances on each code_done. When that number is a multiple of 44, out_special is 1 on every byte of the code; otherwise it is 0.
- R6: A row_valid that arrives after row 75 and before the next start_of_code stores nothing and emits nothing. It sets row_error, which stays set until start_of_code.
- R7: A start_of_code in mid-code drops the partial code. It raises no code_done and does not advance the code number, and the next code's bytes start again at index 0.
- R8: At most one byte appears per cycle, and out_index never exceeds 671.
- R9: A row_valid in the same cycle as start_of_code is taken as row 0 of the new code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_of_code | input | 1 | Re-arms row and byte counters for a new code |
| row_valid | input | 1 | row_data holds the next fixel row |
| row_data | input | 76 | One row of fixels, bit 0 the leftmost |
| out_valid | output | 1 | out_byte, out_index and out_special are valid |
| out_byte | output | 8 | Payload byte |
| out_index | output | 10 | Position of the byte in the payload, 0..671 |
| out_special | output | 1 | Byte belongs to a special code |
| code_done | output | 1 | One-cycle pulse after byte 671 |
| row_error | output | 1 | Surplus row seen since start_of_code |

## Verification
The assertions assume that a band is never completed while the previous band is still being scanned, which means that four rows span at least 39 cycles. The stimulus keeps ten cycles between row strobes, so a band takes forty cycles. Start-of-code is only issued when no band scan is in flight, so every emitted byte can be attributed to one code. Patterns include all-zero, all-one, hashed and single-fixel rows, surplus rows, an aborted code, a start merged with row 0, and a run long enough to reach the next special code.

// File: rtl/fixel_unpack_pkg.sv
package fixel_unpack_pkg;

    localparam int GRID      = 76;
    localparam int BLK_W     = 2;
    localparam int BLK_H     = 4;
    localparam int MARK      = 8;
    localparam int LOGO_LO   = 32;
    localparam int LOGO_SZ   = 12;
    localparam int BYTE_BITS = BLK_W * BLK_H;
    localparam int BLK_COLS  = GRID / BLK_W;
    localparam int BANDS     = GRID / BLK_H;
    localparam int PAYLOAD   = BLK_COLS * BANDS
                             - 4 * (MARK / BLK_W) * (MARK / BLK_H)
                             - (LOGO_SZ / BLK_W) * (LOGO_SZ / BLK_H);
    localparam int ROW_CW    = $clog2(GRID + 1);
    localparam int SUB_W     = $clog2(BLK_H);
    localparam int BAND_W    = $clog2(BANDS);
    localparam int COL_W     = $clog2(BLK_COLS);
    localparam int IDX_W     = $clog2(PAYLOAD);

    typedef logic [GRID-1:0]      row_t;
    typedef row_t [BLK_H-1:0]     band_t;
    typedef logic [BYTE_BITS-1:0] byte_t;

    typedef struct packed {
        logic  valid;
        byte_t data;
    } blk_t;

    // True when the block's top-left fixel sits in a corner marker or the logo
    function automatic logic is_excluded(input logic [BAND_W-1:0] band,
                                         input logic [COL_W-1:0]  col);
        int r0, c0;
        logic edge_r, edge_c, logo;
        r0     = int'(band) * BLK_H;
        c0     = int'(col) * BLK_W;
        edge_r = (r0 < MARK) || (r0 >= GRID - MARK);
        edge_c = (c0 < MARK) || (c0 >= GRID - MARK);
        logo   = (r0 >= LOGO_LO) && (r0 < LOGO_LO + LOGO_SZ) &&
                 (c0 >= LOGO_LO) && (c0 < LOGO_LO + LOGO_SZ);
        return (edge_r && edge_c) || logo;
    endfunction

    // Column-major gather: walk down the left column, then the right one
    function automatic byte_t pack_block(input band_t b,
                                         input logic [COL_W-1:0] col);
        byte_t v;
        for (int k = 0; k < BYTE_BITS; k++)
            v[k] = b[k % BLK_H][int'(col) * BLK_W + k / BLK_H];
        return v;
    endfunction

endpackage

// File: rtl/fixel_band_buf.sv
module fixel_band_buf
    import fixel_unpack_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_of_code,
    input  logic              row_valid,
    input  row_t              row_data,
    output band_t             band_q,
    output logic              band_valid,
    output logic [BAND_W-1:0] band_idx,
    output logic              row_error
);

    row_t              hold [BLK_H];
    logic [ROW_CW-1:0] row_cnt;
    logic [ROW_CW-1:0] cnt_eff;
    logic              take;
    logic              last_of_band;

    always_comb begin
        cnt_eff      = start_of_code ? '0 : row_cnt;
        take         = row_valid && (int'(cnt_eff) < GRID);
        last_of_band = (cnt_eff[SUB_W-1:0] == SUB_W'(BLK_H - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            row_cnt    <= '0;
            band_valid <= 1'b0;
            band_idx   <= '0;
            band_q     <= '0;
            row_error  <= 1'b0;
        end else begin
            band_valid <= 1'b0;
            row_cnt    <= cnt_eff;
            if (start_of_code)
                row_error <= 1'b0;
            if (take) begin
                row_cnt <= cnt_eff + 1'b1;
                if (last_of_band) begin
                    for (int i = 0; i < BLK_H - 1; i++)
                        band_q[i] <= hold[i];
                    band_q[BLK_H-1] <= row_data;
                    band_valid      <= 1'b1;
                    band_idx        <= BAND_W'(cnt_eff >> SUB_W);
                end
            end else if (row_valid) begin
                row_error <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (take && !last_of_band)
            hold[cnt_eff[SUB_W-1:0]] <= row_data;
    end

    a_r6_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        int'(row_cnt) <= GRID);

    a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
        row_error && !start_of_code |=> row_error);

    a_r6_err_set: assert property (@(posedge clk) disable iff (rst)
        row_valid && !start_of_code && int'(row_cnt) == GRID |=> row_error);

endmodule

// File: rtl/fixel_block_scan.sv
module fixel_block_scan
    import fixel_unpack_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              abort,
    input  logic              band_valid,
    input  logic [BAND_W-1:0] band_idx,
    input  band_t             band_q,
    output blk_t              blk
);

    logic              busy;
    logic [COL_W-1:0]  col;
    logic [BAND_W-1:0] band;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            busy <= 1'b0;
            col  <= '0;
            band <= '0;
        end else if (band_valid) begin
            busy <= 1'b1;
            col  <= '0;
            band <= band_idx;
        end else if (busy) begin
            if (int'(col) == BLK_COLS - 1)
                busy <= 1'b0;
            else
                col <= col + 1'b1;
        end
    end

    always_comb begin
        blk.valid = busy && !is_excluded(band, col);
        blk.data  = pack_block(band_q, col);
    end

    // Input rule: a new band may only land once the previous scan is over
    a_r8_band_spacing: assert property (@(posedge clk) disable iff (rst || abort)
        band_valid |-> !busy);

    a_r3_col_bound: assert property (@(posedge clk) disable iff (rst)
        busy |-> int'(col) < BLK_COLS);

endmodule

// File: rtl/fixel_code_unpacker.sv
module fixel_code_unpacker
    import fixel_unpack_pkg::*;
#(
    parameter int SPECIAL_PERIOD = 44
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_of_code,
    input  logic             row_valid,
    input  logic [GRID-1:0]  row_data,
    output logic             out_valid,
    output logic [7:0]       out_byte,
    output logic [IDX_W-1:0] out_index,
    output logic             out_special,
    output logic             code_done,
    output logic             row_error
);

    localparam int SEQ_W = (SPECIAL_PERIOD > 1) ? $clog2(SPECIAL_PERIOD) : 1;

    band_t             band_q;
    logic              band_valid;
    logic [BAND_W-1:0] band_idx;
    blk_t              blk;
    logic [IDX_W-1:0]  nxt_idx;
    logic [SEQ_W-1:0]  seq;
    logic              last_out;

    fixel_band_buf u_band (
        .clk           (clk),
        .rst           (rst),
        .start_of_code (start_of_code),
        .row_valid     (row_valid),
        .row_data      (row_data),
        .band_q        (band_q),
        .band_valid    (band_valid),
        .band_idx      (band_idx),
        .row_error     (row_error)
    );

    fixel_block_scan u_scan (
        .clk        (clk),
        .rst        (rst),
        .abort      (start_of_code),
        .band_valid (band_valid),
        .band_idx   (band_idx),
        .band_q     (band_q),
        .blk        (blk)
    );

    assign last_out = out_valid && (int'(out_index) == PAYLOAD - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_byte    <= '0;
            out_index   <= '0;
            out_special <= 1'b0;
            code_done   <= 1'b0;
            nxt_idx     <= '0;
            seq         <= '0;
        end else begin
            out_valid <= 1'b0;
            code_done <= 1'b0;
            if (start_of_code) begin
                nxt_idx <= '0;
            end else if (blk.valid) begin
                out_valid   <= 1'b1;
                out_byte    <= blk.data;
                out_index   <= nxt_idx;
                out_special <= (seq == '0);
                nxt_idx     <= nxt_idx + 1'b1;
            end
            if (last_out) begin
                code_done <= 1'b1;
                seq       <= (int'(seq) == SPECIAL_PERIOD - 1) ? '0 : seq + 1'b1;
            end
        end
    end

    a_r4_done_single: assert property (@(posedge clk) disable iff (rst)
        code_done |=> !code_done);

    a_r4_done_after_last: assert property (@(posedge clk) disable iff (rst)
        code_done |-> $past(out_valid) && int'($past(out_index)) == PAYLOAD - 1);

    a_r8_index_range: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> int'(out_index) < PAYLOAD);

    a_r3_index_step: assert property (@(posedge clk) disable iff (rst)
        out_valid && $past(out_valid) |-> out_index == $past(out_index) + 1'b1);

    a_r5_special_steady: assert property (@(posedge clk) disable iff (rst)
        out_valid && $past(out_valid) |-> out_special == $past(out_special));

endmodule

// File: tb/fixel_code_unpacker_tb.sv
module fixel_code_unpacker_tb;

    localparam int G  = 76;
    localparam int NB = 672;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_of_code = 1'b0;
    logic         row_valid = 1'b0;
    logic [G-1:0] row_data = '0;
    logic         out_valid;
    logic [7:0]   out_byte;
    logic [9:0]   out_index;
    logic         out_special;
    logic         code_done;
    logic         row_error;

    int   tests = 0;
    int   fails = 0;
    logic [7:0] exp_mem [NB];
    logic [7:0] got_mem [NB];
    int   exp_idx = 0;
    int   bytes_seen = 0;
    int   spec_bytes = 0;
    int   done_cnt = 0;
    int   completed = 0;
    logic exp_special = 1'b0;

    always #4 clk = ~clk;

    fixel_code_unpacker u_dut (
        .clk (clk), .rst (rst), .start_of_code (start_of_code),
        .row_valid (row_valid), .row_data (row_data),
        .out_valid (out_valid), .out_byte (out_byte), .out_index (out_index),
        .out_special (out_special), .code_done (code_done), .row_error (row_error)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic fix(input int pat, input int seed, input int r, input int c);
        logic [15:0] v;
        v = 16'(r * 37 + c * 11 + seed * 5);
        case (pat)
            0:       return 1'b0;
            1:       return 1'b1;
            3:       return (r == 9 && c == 8) || (r == 10 && c == 9);
            default: return v[3] ^ v[0] ^ v[6];
        endcase
    endfunction

    function automatic logic skipped(input int r, input int c);
        logic er, ec;
        er = (r < 8) || (r >= 68);
        ec = (c < 8) || (c >= 68);
        return (er && ec) || (r >= 32 && r <= 43 && c >= 32 && c <= 43);
    endfunction

    task automatic build_exp(input int pat, input int seed);
        int n = 0;
        for (int b = 0; b < G / 4; b++)
            for (int c = 0; c < G / 2; c++)
                if (!skipped(4 * b, 2 * c)) begin
                    for (int k = 0; k < 8; k++)
                        exp_mem[n][k] = fix(pat, seed, 4 * b + k % 4, 2 * c + k / 4);
                    n++;
                end
    endtask

    // Monitor: mid-cycle sampling of registered outputs
    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                chk(int'(out_index) == exp_idx, "R3 index order", int'(out_index), exp_idx);
                if (int'(out_index) < NB) begin
                    chk(out_byte == exp_mem[out_index], "R2 byte value",
                        int'(out_byte), int'(exp_mem[out_index]));
                    got_mem[out_index] = out_byte;
                end
                chk(out_special == exp_special, "R5 special flag",
                    int'(out_special), int'(exp_special));
                if (out_special) spec_bytes++;
                exp_idx++;
                bytes_seen++;
            end
            if (code_done) begin
                done_cnt++;
                chk(bytes_seen == NB, "R4 done after last byte", bytes_seen, NB);
            end
        end
    end

    task automatic send_code(input int pat, input int seed, input int rows, input int extra,
                             input logic merge);
        build_exp(pat, seed);
        exp_special = ((completed % 44) == 0);
        @(posedge clk); #1;
        start_of_code = 1'b1;
        exp_idx = 0; bytes_seen = 0; spec_bytes = 0;
        for (int c = 0; c < G; c++) row_data[c] = fix(pat, seed, 0, c);
        row_valid = merge;
        @(posedge clk); #1;
        start_of_code = 1'b0;
        row_valid = 1'b0;
        for (int r = (merge ? 1 : 0); r < rows + extra; r++) begin
            repeat (9) @(posedge clk);
            #1;
            for (int c = 0; c < G; c++) row_data[c] = fix(pat, seed, r, c);
            row_valid = 1'b1;
            @(posedge clk); #1;
            row_valid = 1'b0;
        end
        repeat (60) @(posedge clk);
        #1;
        if (rows == G) completed++;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!out_valid && !code_done && !out_special && !row_error, "R1 flags at reset",
            int'({out_valid, code_done, out_special, row_error}), 0);
        chk(out_index == 0 && out_byte == 0, "R1 data at reset", int'(out_index), 0);
    endtask

    task automatic t_basic();
        int d0 = done_cnt;
        send_code(2, 1, G, 0, 1'b0);
        chk(bytes_seen == NB, "R3 byte count", bytes_seen, NB);
        chk(done_cnt == d0 + 1, "R4 one done pulse", done_cnt - d0, 1);
        chk(spec_bytes == NB, "R5 code 0 special", spec_bytes, NB);
    endtask

    task automatic t_bitorder();
        send_code(3, 0, G, 0, 1'b0);
        chk(got_mem[64] == 8'h42, "R2 column-major bits", int'(got_mem[64]), 'h42);
        chk(got_mem[63] == 8'h00, "R2 neighbour clear", int'(got_mem[63]), 0);
        chk(spec_bytes == 0, "R5 code 1 not special", spec_bytes, 0);
    endtask

    task automatic t_ones();
        send_code(1, 0, G, 0, 1'b0);
        chk(bytes_seen == NB, "R3 skips 50 blocks", bytes_seen, NB);
    endtask

    task automatic t_extra();
        int d0 = done_cnt;
        send_code(2, 7, G, 2, 1'b0);
        chk(row_error == 1'b1, "R6 error raised", int'(row_error), 1);
        chk(bytes_seen == NB, "R6 no extra bytes", bytes_seen, NB);
        chk(done_cnt == d0 + 1, "R6 single done", done_cnt - d0, 1);
        @(posedge clk); #1 start_of_code = 1'b1;
        @(posedge clk); #1 start_of_code = 1'b0;
        @(negedge clk);
        chk(row_error == 1'b0, "R6 error cleared by start", int'(row_error), 0);
    endtask

    task automatic t_abort();
        int d0 = done_cnt;
        send_code(2, 9, 30, 0, 1'b0);
        chk(bytes_seen == 250, "R7 partial bytes", bytes_seen, 250);
        chk(done_cnt == d0, "R7 no done on abort", done_cnt - d0, 0);
        send_code(2, 11, G, 0, 1'b0);
        chk(bytes_seen == NB, "R7 restart from index 0", bytes_seen, NB);
        chk(spec_bytes == 0, "R7 abort kept code number", spec_bytes, 0);
    endtask

    task automatic t_merge();
        send_code(2, 13, G, 0, 1'b1);
        chk(bytes_seen == NB, "R9 merged start row 0", bytes_seen, NB);
    endtask

    task automatic t_special();
        while (completed < 44) send_code(2, completed, G, 0, 1'b0);
        send_code(2, 99, G, 0, 1'b0);
        chk(spec_bytes == NB, "R5 code 44 special", spec_bytes, NB);
        chk(bytes_seen == NB, "R8 full count", bytes_seen, NB);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_basic();
        t_bitorder();
        t_ones();
        t_extra();
        t_abort();
        t_merge();
        t_special();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule